// File: doc/BRIEF.md
# Dual-Threshold Cascode Gate Sequencer

This block sits on the receive side of an isolated gate driver. The driver controls a normally-on main power transistor that is wired in series with a low-voltage protection switch. The block takes the received switching command, a shutdown request, two digital comparator flags for the regulated supply and a bootstrap-mode select. From these it produces the gate commands for both switches and a status line for the controller.

The block works in one of three operating modes, named after its internal encoding:

- **DISABLED**: both gates are held off.
- **NORMAL**: the supply is above the upper threshold. The series switch is held on, and only the main switch follows the command.
- **BOOT_SWITCHING**: bootstrap mode is selected and the supply lies between the lower and upper thresholds. Both switches follow every command, and the status line repeats the command so that the controller knows the supply is reduced.

An interlock always orders the two gates. The main gate may only rise while the series gate is on and has settled for a parameterised number of cycles. The series gate may only fall after the main gate is already off. Each comparator flag passes through a persistence filter, so a short glitch cannot move the mode.

Top module: `cascode_gate_sequencer`

## Requirements
- R1: During and directly after reset, `series_gate`, `main_gate` and `boot_status` are 0.
- R2: With `boot_mode` = 0 and the upper flag `cmp_high` low, the block is DISABLED. Both gates stay 0 whatever the command and the `cmp_low` flag are.
- R3: In NORMAL (filtered `cmp_high` = 1, either `boot_mode`), `series_gate` is 1 while idle. `main_gate` rises at the first clock edge that samples `cmd_on` = 1, and falls at the first edge that samples it 0.
- R4: In BOOT_SWITCHING (`boot_mode` = 1, filtered `cmp_low` = 1, filtered `cmp_high` = 0), `series_gate` turns on with each on-command. It turns off one edge after `main_gate` falls on an off-command.
- R5: In NORMAL, `series_gate` stays 1 when the command goes low. Only `main_gate` toggles.
- R6: `main_gate` is never 1 while `series_gate` is 0. `series_gate` never falls at an edge where `main_gate` was 1 before that edge.
- R7: When `series_gate` rises, `main_gate` follows SETTLE_CYC+1 edges later. In BOOT_SWITCHING, the command-to-main latency is therefore SETTLE_CYC+2 edges, against 1 edge in NORMAL.
- R8: `cmd_shutdown` = 1 forces `main_gate` to 0 at the next edge, overriding `cmd_on`. In NORMAL, `series_gate` stays 1.
- R9: `boot_status` equals `cmd_on` & ~`cmd_shutdown`, registered one edge, only while in BOOT_SWITCHING. It is 0 in DISABLED and in NORMAL.
- R10: When the active threshold is lost, `main_gate` falls first and `series_gate` falls at a later edge. With the upper flag dropped at edge 1 and `cmd_on` held high in NORMAL, `main_gate` is 0 after edge FILT_CYC+2.
- R11: A comparator flag change that lasts fewer than FILT_CYC consecutive sampled cycles has no effect on the mode or on the gates. A change that lasts FILT_CYC cycles is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_mode | input | 1 | 1 enables the lower threshold and BOOT_SWITCHING |
| cmp_low | input | 1 | Supply above the lower (bootstrap) threshold |
| cmp_high | input | 1 | Supply above the upper (primary) threshold |
| cmd_on | input | 1 | Received switching command, 1 = main switch on |
| cmd_shutdown | input | 1 | Received shutdown request, forces the main switch off |
| series_gate | output | 1 | Gate command of the series protection switch |
| main_gate | output | 1 | Gate command of the main switch |
| boot_status | output | 1 | Command echo while between thresholds |

## Verification
The bench walks every combination of bootstrap select and the two comparator flags. In each case it measures, in edges, how long the main gate takes to rise after a command. A design that skipped the settle wait would show NORMAL latency in the bootstrap region, and one that ignored the lower threshold would never switch there. On every sampled cycle the bench checks gate order, which catches a design that drops both gates together on an off-command, on a shutdown or on loss of threshold. It also applies comparator glitches one cycle shorter than the filter length, and then pulses exactly that long. A design without hysteresis would briefly turn the series switch on, and one with an off-by-one filter would reject the full-length pulse.

// File: rtl/cascode_gate_sequencer.sv
module cascode_gate_sequencer #(
  parameter int SETTLE_CYC = 4,
  parameter int FILT_CYC   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_mode,
  input  logic cmp_low,
  input  logic cmp_high,
  input  logic cmd_on,
  input  logic cmd_shutdown,
  output logic series_gate,
  output logic main_gate,
  output logic boot_status
);

  localparam int FW = (FILT_CYC < 1) ? 1 : $clog2(FILT_CYC + 1);
  localparam int SW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);

  typedef enum logic [1:0] {DISABLED, BOOT_SWITCHING, NORMAL} mode_t;

  logic [1:0] raw, filt;
  assign raw = {cmp_high, cmp_low};

  for (genvar i = 0; i < 2; i++) begin : g_filt
    logic [FW-1:0] run;
    logic          f;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run <= '0;
        f   <= 1'b0;
      end else if (raw[i] == f) begin
        run <= '0;
      end else if (run == FW'(FILT_CYC - 1)) begin
        run <= '0;
        f   <= raw[i];
      end else begin
        run <= run + 1'b1;
      end
    end
    assign filt[i] = f;
  end

  mode_t mode_q, mode_d;
  always_comb begin
    if (filt[1])                   mode_d = NORMAL;
    else if (boot_mode && filt[0]) mode_d = BOOT_SWITCHING;
    else                           mode_d = DISABLED;
  end

  logic series_q, main_q, stat_q;
  logic [SW-1:0] settle_q;

  wire main_want   = (mode_q != DISABLED) & cmd_on & ~cmd_shutdown;
  wire series_want = (mode_q == NORMAL) | ((mode_q == BOOT_SWITCHING) & main_want);
  wire settled     = series_q & (settle_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= DISABLED;
      series_q <= 1'b0;
      main_q   <= 1'b0;
      settle_q <= '0;
      stat_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      stat_q <= (mode_q == BOOT_SWITCHING) & cmd_on & ~cmd_shutdown;

      if (series_want && !series_q) begin
        series_q <= 1'b1;
        settle_q <= SW'(SETTLE_CYC);
      end else begin
        if (!series_want && series_q && !main_q) series_q <= 1'b0;
        if (settle_q != '0) settle_q <= settle_q - 1'b1;
      end

      if (!main_want)   main_q <= 1'b0;
      else if (settled) main_q <= 1'b1;
    end
  end

  assign series_gate = series_q;
  assign main_gate   = main_q;
  assign boot_status = stat_q;

  p_main_needs_series_r6: assert property (@(posedge clk) disable iff (!rst_n)
    main_q |-> series_q);

  p_series_after_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(series_q) |-> !$past(main_q));

  p_main_rise_settled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_q) |-> $past(series_q));

  p_shutdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_shutdown |=> !main_q);

  p_disabled_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == DISABLED) |=> !main_q);

  p_normal_holds_series_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == NORMAL && series_q) |=> series_q);

  p_status_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != BOOT_SWITCHING) |=> !stat_q);

endmodule

// File: tb/tb_cascode_gate_sequencer.sv
`timescale 1ns/1ps
module tb_cascode_gate_sequencer;
  localparam int SETTLE = 3;
  localparam int FILT   = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic boot_mode = 1'b0, cmp_low = 1'b0, cmp_high = 1'b0;
  logic cmd_on = 1'b0, cmd_shutdown = 1'b0;
  logic series_gate, main_gate, boot_status;

  int vectors = 0, fails = 0;
  bit mon_en = 1'b0, done = 1'b0;
  logic prev_main = 1'b0, prev_series = 1'b0;

  always #2 clk = ~clk;

  cascode_gate_sequencer #(.SETTLE_CYC(SETTLE), .FILT_CYC(FILT)) dut (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .cmp_low(cmp_low),
    .cmp_high(cmp_high), .cmd_on(cmd_on), .cmd_shutdown(cmd_shutdown),
    .series_gate(series_gate), .main_gate(main_gate), .boot_status(boot_status));

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      vectors++;
      if (main_gate && !series_gate) begin
        fails++;
        $display("FAIL R6: actual main=1 series=0 expected series=1 at %0t", $time);
      end
      if (prev_series && !series_gate && prev_main) begin
        fails++;
        $display("FAIL R10: actual series fell with main=1 expected main off first at %0t", $time);
      end
    end
    prev_main   = main_gate;
    prev_series = series_gate;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    int seen;
    cyc(3);
    chk("R1 series in reset", series_gate, 0);
    chk("R1 main in reset", main_gate, 0);
    chk("R1 status in reset", boot_status, 0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 series after reset", series_gate, 0);
    chk("R1 main after reset", main_gate, 0);
    mon_en = 1'b1;

    // R2 R3 R4 R5 R7 R9 sweep: boot select x comparator flags
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < 4; c++) begin
        int md;
        md = (c >= 2) ? 2 : ((b == 1 && c[0]) ? 1 : 0);
        boot_mode = b[0]; cmp_low = c[0]; cmp_high = c[1]; cmd_on = 1'b0;
        cyc(12);
        chk($sformatf("R5 idle series b=%0d c=%0d", b, c), series_gate, md == 2);
        chk($sformatf("R2 idle main b=%0d c=%0d", b, c), main_gate, 0);
        cmd_on = 1'b1;
        lat = 99;
        for (int k = 1; k <= 20; k++) begin
          @(negedge clk);
          if (main_gate) begin lat = k; break; end
        end
        chk($sformatf("R7 on-latency b=%0d c=%0d", b, c), lat,
            md == 0 ? 99 : (md == 2 ? 1 : SETTLE + 2));
        cyc(3);
        chk($sformatf("R9 status b=%0d c=%0d", b, c), boot_status, md == 1);
        chk($sformatf("R4 series on b=%0d c=%0d", b, c), series_gate, md != 0);
        cmd_on = 1'b0;
        cyc(1);
        chk($sformatf("R3 main off b=%0d c=%0d", b, c), main_gate, 0);
        chk($sformatf("R4 series held b=%0d c=%0d", b, c), series_gate, md != 0);
        cyc(1);
        chk($sformatf("R4 series after b=%0d c=%0d", b, c), series_gate, md == 2);
        cyc(3);
        chk($sformatf("R5 series stays b=%0d c=%0d", b, c), series_gate, md == 2);
        chk($sformatf("R9 status off b=%0d c=%0d", b, c), boot_status, 0);
      end
    end

    // R8 shutdown in NORMAL
    boot_mode = 1'b0; cmp_low = 1'b1; cmp_high = 1'b1; cmd_on = 1'b1;
    cyc(12);
    chk("R3 main on", main_gate, 1);
    cmd_shutdown = 1'b1;
    cyc(1);
    chk("R8 main forced off", main_gate, 0);
    chk("R8 series kept", series_gate, 1);
    cyc(4);
    chk("R8 main held off", main_gate, 0);
    cmd_shutdown = 1'b0;
    cyc(1);
    chk("R8 main resumes", main_gate, 1);

    // R8 shutdown in BOOT_SWITCHING
    boot_mode = 1'b1; cmp_high = 1'b0;
    cyc(12);
    chk("R4 boot main on", main_gate, 1);
    cmd_shutdown = 1'b1;
    cyc(1);
    chk("R8 boot main off", main_gate, 0);
    chk("R8 boot series held", series_gate, 1);
    cyc(1);
    chk("R8 boot series off", series_gate, 0);
    chk("R9 status on shutdown", boot_status, 0);
    cmd_shutdown = 1'b0;
    cyc(12);

    // R10 threshold loss in NORMAL
    boot_mode = 1'b0; cmp_high = 1'b1; cmd_on = 1'b1;
    cyc(12);
    chk("R10 main on before loss", main_gate, 1);
    cmp_high = 1'b0;
    lat = 99;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (!main_gate) begin lat = k; break; end
    end
    chk("R10 main off latency", lat, FILT + 2);
    chk("R10 series still on", series_gate, 1);
    cyc(1);
    chk("R10 series off next", series_gate, 0);

    // R11 short glitch on upper flag while disabled
    cmp_high = 1'b1;
    cyc(FILT - 1);
    cmp_high = 1'b0;
    seen = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (series_gate || main_gate) seen = 1;
    end
    chk("R11 short glitch ignored", seen, 0);

    // R11 full-length pulse accepted
    cmp_high = 1'b1;
    cyc(FILT);
    cmp_high = 1'b0;
    seen = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (series_gate) seen = 1;
    end
    chk("R11 full pulse accepted", seen, 1);

    // R11 short dropout in NORMAL keeps main on
    cmp_high = 1'b1;
    cyc(12);
    cmp_high = 1'b0;
    cyc(FILT - 1);
    cmp_high = 1'b1;
    seen = 1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (!main_gate) seen = 0;
    end
    chk("R11 dropout ignored", seen, 1);

    // R2 lower flag alone without bootstrap
    cmp_high = 1'b0; cmp_low = 1'b1; boot_mode = 1'b0;
    cyc(12);
    chk("R2 disabled main", main_gate, 0);
    chk("R2 disabled series", series_gate, 0);
    chk("R9 disabled status", boot_status, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule